// File: doc/BRIEF.md
# Interrupt Priority and Entry Sequencer

This block sits beside the instruction sequencer of an 8-bit big-endian processor and takes over at every instruction boundary. When the core raises `boundary`, the block looks at the halt, reset, non-maskable, fast and normal interrupt request lines together with the mask bits of the condition-code byte. It picks one outcome: stay halted, take an event, or let the core fetch the next opcode.

For a taken event the block first stacks the machine state through a byte-wide write port onto the hardware stack. It then reads a two-byte vector from the top memory page through a read port. When the vector is in, it pulses `done` and presents the new program counter, condition codes, direct-page value, stack pointer and the nominal instruction-cycle cost of the entry. The core copies these into its register file. The fast request saves only the return address and condition codes. The non-maskable and normal requests save every programmer-visible register.

Top module: `irq_entry_seq`

## Requirements
- R1: When `boundary` is high in the idle state, the block chooses exactly one outcome, in this priority order: halt (`halt_n` low), reset (`reset_n` low), pending NMI, FIRQ, IRQ, fetch. `fetch` is high in that same cycle only when no event is chosen and `halt_n` is high. `kind` reports the event taken: 1 reset, 2 NMI, 3 FIRQ, 4 IRQ.
- R2: The non-maskable request is latched on a high-to-low transition of `nmi_n`, even when the pulse ends before the next boundary. Holding the line low does not make the request pending again. A taken NMI or a taken reset clears the latch.
- R3: A reset event writes nothing to the stack. It leaves the stack pointer unchanged and returns direct page 0. It returns the condition codes with bit 4 (I) and bit 6 (F) set and all other bits unchanged. The cost is 0.
- R4: NMI and IRQ entries write 12 bytes. Each byte goes to the current stack address, after which the address drops by one. The bytes, in write order, are PC low, PC high, U low, U high, Y low, Y high, X low, X high, DP, B, A, CC. The returned stack pointer is the input value minus 12.
- R5: The CC byte stacked by NMI and IRQ has bit 7 (E) set. After entry, NMI returns CC with E, I and F set, and IRQ returns CC with E and I set and F unchanged. Both report a cost of 21.
- R6: FIRQ entry writes only PC low, PC high and then CC with E cleared. It returns the stack pointer minus 3 and CC with E cleared and I and F set, and reports a cost of 12.
- R7: FIRQ is ignored while CC bit 6 is set, and IRQ is ignored while CC bit 4 is set. In that case the next lower-priority outcome is chosen.
- R8: The vector comes from address FFFE for reset, FFFC for NMI, FFF8 for IRQ and FFF6 for FIRQ. The high byte is read first, then the byte at the next address. Read data is taken one cycle after `rd_en`. `pc_out` equals the high byte followed by the low byte.
- R9: While idle with `halt_n` low, `ba` and `bs` are both high. Whenever the block is writing the stack or reading a vector, `ba` is low and `bs` is high. At all other times both are low.
- R10: `done` is a single-cycle pulse in the cycle the new register values first appear. It drops for at least one cycle before it can pulse again, and `busy` is high from the cycle after acceptance until `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous block reset |
| boundary | input | 1 | Core is at an instruction boundary |
| halt_n | input | 1 | Halt request, active low |
| reset_n | input | 1 | Processor reset request, active low |
| nmi_n | input | 1 | Non-maskable request, falling-edge |
| firq_n | input | 1 | Fast interrupt request, active low |
| irq_n | input | 1 | Normal interrupt request, active low |
| cc_in | input | 8 | Current condition codes |
| dp_in | input | 8 | Current direct-page register |
| a_in | input | 8 | Accumulator A |
| b_in | input | 8 | Accumulator B |
| x_in | input | 16 | Index X |
| y_in | input | 16 | Index Y |
| u_in | input | 16 | User stack pointer |
| s_in | input | 16 | Hardware stack pointer |
| pc_in | input | 16 | Return address |
| wr_en | output | 1 | Stack byte write strobe |
| wr_addr | output | 16 | Stack write address |
| wr_data | output | 8 | Stack write data |
| rd_en | output | 1 | Vector byte read strobe |
| rd_addr | output | 16 | Vector read address |
| rd_data | input | 8 | Read data, valid one cycle after rd_en |
| fetch | output | 1 | No event: core fetches the next opcode |
| busy | output | 1 | Entry sequence in progress |
| done | output | 1 | New register values valid |
| kind | output | 3 | Event taken (1 reset, 2 NMI, 3 FIRQ, 4 IRQ) |
| pc_out | output | 16 | New program counter |
| cc_out | output | 8 | New condition codes |
| dp_out | output | 8 | New direct-page value |
| s_out | output | 16 | New hardware stack pointer |
| cycles | output | 5 | Nominal cost of the entry |
| ba | output | 1 | Bus status A |
| bs | output | 1 | Bus status S |

## Verification
The hardest situation to reach from the ports is a non-maskable edge that arrives while the request cannot be served. This includes a short low pulse between boundaries, an edge during a halt, and a line held low across several boundaries, where the latch must keep or drop the request correctly. The stimulus applies directed pulses and long holds. It then mixes random line levels with random CC masks over many back-to-back boundaries, while a bench model tracks the pending request independently, so that NMI edges coincide with halts, resets and masked requests.

// File: rtl/irq_entry_seq.sv
`timescale 1ns/100ps
module irq_entry_seq #(
  parameter int DW = 8,
  parameter logic [7:0] VEC_PAGE = 8'hFF,
  parameter logic [7:0] VOFS_RESET = 8'hFE,
  parameter logic [7:0] VOFS_NMI = 8'hFC,
  parameter logic [7:0] VOFS_IRQ = 8'hF8,
  parameter logic [7:0] VOFS_FIRQ = 8'hF6,
  parameter int COST_FULL = 21,
  parameter int COST_FAST = 12,
  parameter int COST_RESET = 0,
  parameter int CYW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boundary,
  input  logic              halt_n,
  input  logic              reset_n,
  input  logic              nmi_n,
  input  logic              firq_n,
  input  logic              irq_n,
  input  logic [DW-1:0]     cc_in,
  input  logic [DW-1:0]     dp_in,
  input  logic [DW-1:0]     a_in,
  input  logic [DW-1:0]     b_in,
  input  logic [2*DW-1:0]   x_in,
  input  logic [2*DW-1:0]   y_in,
  input  logic [2*DW-1:0]   u_in,
  input  logic [2*DW-1:0]   s_in,
  input  logic [2*DW-1:0]   pc_in,
  output logic              wr_en,
  output logic [2*DW-1:0]   wr_addr,
  output logic [DW-1:0]     wr_data,
  output logic              rd_en,
  output logic [2*DW-1:0]   rd_addr,
  input  logic [DW-1:0]     rd_data,
  output logic              fetch,
  output logic              busy,
  output logic              done,
  output logic [2:0]        kind,
  output logic [2*DW-1:0]   pc_out,
  output logic [DW-1:0]     cc_out,
  output logic [DW-1:0]     dp_out,
  output logic [2*DW-1:0]   s_out,
  output logic [CYW-1:0]    cycles,
  output logic              ba,
  output logic              bs
);
  localparam int AW = 2 * DW;
  localparam int NPUSH = 12;
  localparam int IW = $clog2(NPUSH);
  localparam logic [DW-1:0] M_E = DW'(1) << 7;
  localparam logic [DW-1:0] M_F = DW'(1) << 6;
  localparam logic [DW-1:0] M_I = DW'(1) << 4;
  localparam logic [2:0] K_NONE = 3'd0, K_RESET = 3'd1, K_NMI = 3'd2,
                         K_FIRQ = 3'd3, K_IRQ = 3'd4, K_HALT = 3'd5;

  typedef enum logic [1:0] {S_IDLE, S_PUSH, S_V0, S_V1} st_t;
  st_t st;
  logic v2;

  logic nmi_prev, nmi_pend, nmi_req;
  logic [2:0] evt;
  logic accept;
  logic [IW-1:0] idx;
  logic [AW-1:0] s_cur, vec, sv_pc, sv_u, sv_y, sv_x;
  logic [DW-1:0] sv_dp, sv_a, sv_b, sv_cc, cc_new, dp_new, hi;
  logic [CYW-1:0] cost;
  logic [DW-1:0] push_byte;

  assign nmi_req = nmi_pend | (nmi_prev & ~nmi_n);

  always_comb begin
    if (!halt_n)                    evt = K_HALT;
    else if (!reset_n)              evt = K_RESET;
    else if (nmi_req)               evt = K_NMI;
    else if (!firq_n && !(|(cc_in & M_F))) evt = K_FIRQ;
    else if (!irq_n && !(|(cc_in & M_I)))  evt = K_IRQ;
    else                            evt = K_NONE;
  end

  wire idle_bnd = (st == S_IDLE) && !v2 && boundary;
  assign accept = idle_bnd && (evt != K_NONE) && (evt != K_HALT);
  assign fetch  = idle_bnd && (evt == K_NONE);
  assign busy   = (st != S_IDLE) || v2;

  always_comb begin
    case (idx)
      IW'(0):  push_byte = sv_pc[DW-1:0];
      IW'(1):  push_byte = sv_pc[AW-1:DW];
      IW'(2):  push_byte = sv_u[DW-1:0];
      IW'(3):  push_byte = sv_u[AW-1:DW];
      IW'(4):  push_byte = sv_y[DW-1:0];
      IW'(5):  push_byte = sv_y[AW-1:DW];
      IW'(6):  push_byte = sv_x[DW-1:0];
      IW'(7):  push_byte = sv_x[AW-1:DW];
      IW'(8):  push_byte = sv_dp;
      IW'(9):  push_byte = sv_b;
      IW'(10): push_byte = sv_a;
      default: push_byte = sv_cc;
    endcase
  end

  assign wr_en   = (st == S_PUSH);
  assign wr_addr = s_cur;
  assign wr_data = push_byte;
  assign rd_en   = (st == S_V0) || (st == S_V1);
  assign rd_addr = (st == S_V1) ? (vec | AW'(1)) : vec;

  assign ba = (st == S_IDLE) && !v2 && !halt_n;
  assign bs = ba || busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      v2 <= 1'b0;
      nmi_prev <= 1'b1;
      nmi_pend <= 1'b0;
      idx <= '0;
      s_cur <= '0; vec <= '0;
      sv_pc <= '0; sv_u <= '0; sv_y <= '0; sv_x <= '0;
      sv_dp <= '0; sv_a <= '0; sv_b <= '0; sv_cc <= '0;
      cc_new <= '0; dp_new <= '0; hi <= '0; cost <= '0;
      done <= 1'b0; kind <= K_NONE;
      pc_out <= '0; cc_out <= '0; dp_out <= '0; s_out <= '0; cycles <= '0;
    end else begin
      nmi_prev <= nmi_n;
      nmi_pend <= (accept && (evt == K_RESET || evt == K_NMI)) ? 1'b0 : nmi_req;
      done <= 1'b0;
      v2 <= 1'b0;
      if (v2) begin
        pc_out <= {hi, rd_data};
        cc_out <= cc_new;
        dp_out <= dp_new;
        s_out  <= s_cur;
        cycles <= cost;
        done   <= 1'b1;
      end
      case (st)
        S_IDLE: if (accept) begin
          kind  <= evt;
          idx   <= '0;
          s_cur <= s_in;
          sv_pc <= pc_in; sv_u <= u_in; sv_y <= y_in; sv_x <= x_in;
          sv_dp <= dp_in; sv_a <= a_in; sv_b <= b_in;
          dp_new <= dp_in;
          case (evt)
            K_RESET: begin
              st <= S_V0; vec <= {VEC_PAGE, VOFS_RESET};
              dp_new <= '0; sv_cc <= cc_in;
              cc_new <= cc_in | M_I | M_F; cost <= CYW'(COST_RESET);
            end
            K_NMI: begin
              st <= S_PUSH; vec <= {VEC_PAGE, VOFS_NMI};
              sv_cc <= cc_in | M_E;
              cc_new <= cc_in | M_E | M_I | M_F; cost <= CYW'(COST_FULL);
            end
            K_FIRQ: begin
              st <= S_PUSH; vec <= {VEC_PAGE, VOFS_FIRQ};
              sv_cc <= cc_in & ~M_E;
              cc_new <= (cc_in & ~M_E) | M_I | M_F; cost <= CYW'(COST_FAST);
            end
            default: begin
              st <= S_PUSH; vec <= {VEC_PAGE, VOFS_IRQ};
              sv_cc <= cc_in | M_E;
              cc_new <= cc_in | M_E | M_I; cost <= CYW'(COST_FULL);
            end
          endcase
        end
        S_PUSH: begin
          s_cur <= s_cur - 1'b1;
          if (idx == IW'(NPUSH - 1))
            st <= S_V0;
          else if (kind == K_FIRQ && idx == IW'(1))
            idx <= IW'(NPUSH - 1);
          else
            idx <= idx + 1'b1;
        end
        S_V0: st <= S_V1;
        S_V1: begin
          hi <= rd_data;
          v2 <= 1'b1;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_stack_desc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(wr_en)) |-> (wr_addr == $past(wr_addr) - 1'b1));

  p_vec_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && $past(rd_en)) |-> (rd_addr == $past(rd_addr) + 1'b1));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_bus_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en || rd_en) |-> (!ba && bs));

  p_fast_masks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && kind == K_FIRQ) |-> (cc_out[6] && cc_out[4] && !cc_out[7]));

  p_irq_masks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && kind == K_IRQ) |-> (cc_out[7] && cc_out[4]));

  p_reset_dp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && kind == K_RESET) |-> (dp_out == '0 && cc_out[6] && cc_out[4]));

  p_no_write_on_fetch_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fetch |=> !wr_en && !rd_en);
endmodule

// File: tb/irq_entry_seq_test.sv
`timescale 1ns/100ps
module irq_entry_seq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic boundary = 0, halt_n = 1, reset_n = 1, nmi_n = 1, firq_n = 1, irq_n = 1;
  logic [7:0] cc_in = 0, dp_in = 0, a_in = 0, b_in = 0;
  logic [15:0] x_in = 0, y_in = 0, u_in = 0, s_in = 0, pc_in = 0;
  logic wr_en, rd_en, fetch, busy, done, ba, bs;
  logic [15:0] wr_addr, rd_addr, pc_out, s_out;
  logic [7:0] wr_data, cc_out, dp_out;
  logic [7:0] rd_data = 0;
  logic [2:0] kind;
  logic [4:0] cycles;

  irq_entry_seq uut (
    .clk(clk), .rst_n(rst_n), .boundary(boundary), .halt_n(halt_n), .reset_n(reset_n),
    .nmi_n(nmi_n), .firq_n(firq_n), .irq_n(irq_n), .cc_in(cc_in), .dp_in(dp_in),
    .a_in(a_in), .b_in(b_in), .x_in(x_in), .y_in(y_in), .u_in(u_in), .s_in(s_in),
    .pc_in(pc_in), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .fetch(fetch), .busy(busy), .done(done),
    .kind(kind), .pc_out(pc_out), .cc_out(cc_out), .dp_out(dp_out), .s_out(s_out),
    .cycles(cycles), .ba(ba), .bs(bs));

  int nchk = 0, nfail = 0;
  logic [7:0] salt = 8'h5A;
  int nw = 0;
  logic [15:0] wa [16];
  logic [7:0]  wd [16];
  bit m_prev = 1, m_pend = 0;

  function automatic logic [7:0] vb(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ salt;
  endfunction

  always @(posedge clk) begin
    if (rd_en) rd_data <= vb(rd_addr);
    if (boundary) nw <= 0;
    else if (wr_en && nw < 16) begin
      wa[nw] <= wr_addr; wd[nw] <= wr_data; nw <= nw + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic nmi_pulse();
    @(negedge clk); nmi_n = 0;
    @(negedge clk); nmi_n = 1;
    if (m_prev) m_pend = 1;
    m_prev = 1;
  endtask

  task automatic trial(input bit h, input bit r, input bit nm, input bit f, input bit q,
                       input logic [7:0] cc);
    int ev, np, cost, n;
    bit edge_, req;
    logic [15:0] vec, es;
    logic [7:0] ecc, pcc, edp;
    logic [7:0] eb [12];
    @(negedge clk);
    halt_n = ~h; reset_n = ~r; nmi_n = ~nm; firq_n = ~f; irq_n = ~q; cc_in = cc;
    pc_in = 16'($urandom); x_in = 16'($urandom); y_in = 16'($urandom); u_in = 16'($urandom);
    a_in = 8'($urandom); b_in = 8'($urandom); dp_in = 8'($urandom);
    s_in = 16'h0400 + 16'($urandom % 2048); salt = 8'($urandom);
    edge_ = m_prev && nm; req = m_pend || edge_; m_prev = !nm;
    if (h) ev = 5; else if (r) ev = 1; else if (req) ev = 2;
    else if (f && !cc[6]) ev = 3; else if (q && !cc[4]) ev = 4; else ev = 0;
    m_pend = (ev == 1 || ev == 2) ? 0 : req;
    boundary = 1;
    #1;
    chk("R1 fetch strobe", fetch, ev == 0);
    chk("R9 ba at boundary", ba, ev == 5);
    chk("R9 bs at boundary", bs, ev == 5);
    @(negedge clk);
    boundary = 0;
    if (ev == 0 || ev == 5) begin
      chk("R1 no sequence started", busy, 0);
      if (ev == 5) chk("R9 halt status", {ba, bs}, 2'b11);
      return;
    end
    chk("R9 vectoring status", {ba, bs}, 2'b01);
    chk("R10 busy", busy, 1);
    n = 0;
    while (!done && n < 40) begin @(negedge clk); n++; end
    chk("R10 done reached", done, 1);
    chk("R1 kind", kind, ev);
    edp = dp_in; es = s_in; np = 12; cost = 21;
    pcc = cc | 8'h80;
    case (ev)
      1: begin vec = 16'hFFFE; ecc = cc | 8'h50; edp = 0; np = 0; cost = 0; end
      2: begin vec = 16'hFFFC; ecc = cc | 8'hD0; end
      3: begin vec = 16'hFFF6; pcc = cc & 8'h7F; ecc = (cc & 8'h7F) | 8'h50; np = 3; cost = 12; end
      default: begin vec = 16'hFFF8; ecc = cc | 8'h90; end
    endcase
    es = s_in - 16'(np);
    chk("R8 vector pc", pc_out, {vb(vec), vb(vec | 16'h1)});
    chk(ev == 1 ? "R3 cc" : ev == 3 ? "R6 cc" : "R5 cc", cc_out, ecc);
    chk(ev == 1 ? "R3 dp" : "R4 dp", dp_out, edp);
    chk(ev == 3 ? "R6 stack pointer" : "R4 stack pointer", s_out, es);
    chk(ev == 3 ? "R6 cost" : ev == 1 ? "R3 cost" : "R5 cost", cycles, cost);
    chk(ev == 1 ? "R3 write count" : "R4 write count", nw, np);
    eb[0] = pc_in[7:0]; eb[1] = pc_in[15:8]; eb[2] = u_in[7:0]; eb[3] = u_in[15:8];
    eb[4] = y_in[7:0]; eb[5] = y_in[15:8]; eb[6] = x_in[7:0]; eb[7] = x_in[15:8];
    eb[8] = dp_in; eb[9] = b_in; eb[10] = a_in; eb[11] = pcc;
    for (int k = 0; k < np && k < nw; k++) begin
      chk(ev == 3 ? "R6 stack addr" : "R4 stack addr", wa[k], s_in - 16'(k));
      chk(ev == 3 ? "R6 stack byte" : "R4 stack byte", wd[k], (ev == 3 && k == 2) ? eb[11] : eb[k]);
    end
    @(negedge clk);
    chk("R10 done is a pulse", done, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    nchk++; nfail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    void'($urandom(32'h1D0F));
    repeat (3) @(negedge clk);
    chk("R10 reset busy", busy, 0);
    chk("R10 reset done", done, 0);
    chk("R4 reset wr_en", wr_en, 0);
    chk("R8 reset rd_en", rd_en, 0);
    chk("R1 reset fetch", fetch, 0);
    rst_n = 1;
    @(negedge clk);
    trial(0, 1, 0, 1, 1, 8'h00);   // R3 reset beats FIRQ/IRQ
    trial(0, 0, 1, 1, 1, 8'h00);   // R2 NMI edge wins over FIRQ
    trial(0, 0, 1, 0, 0, 8'h00);   // R2 still low: not pending again, fetch
    nmi_pulse();                   // R2 short pulse is remembered
    trial(0, 0, 0, 0, 0, 8'h00);
    trial(0, 0, 0, 1, 1, 8'h40);   // R7 FIRQ masked, IRQ taken
    trial(0, 0, 0, 1, 1, 8'h50);   // R7 both masked: fetch
    trial(0, 0, 0, 1, 0, 8'h80);   // R6 FIRQ clears E
    nmi_pulse();
    trial(1, 1, 0, 1, 1, 8'h00);   // R9 halt wins, NMI stays pending
    trial(0, 0, 0, 0, 0, 8'h00);   // R2 pending NMI served after halt
    nmi_pulse();
    trial(0, 1, 0, 0, 0, 8'hFF);   // R3 reset clears pending NMI
    trial(0, 0, 0, 0, 0, 8'h00);   // R2 nothing left: fetch
    for (int t = 0; t < 120; t++)
      trial(($urandom % 10) == 0, ($urandom % 10) == 0, ($urandom % 4) == 0,
            ($urandom % 3) == 0, ($urandom % 3) == 0, 8'($urandom));
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule